// File: doc/BRIEF.md
# Condition Code Evaluator with Flag Register

This block keeps the four arithmetic status flags (negative, zero, carry, overflow) of a processor core and decides whether a conditional instruction or branch executes. The flags are loaded from the ALU at the end of a flag-setting operation. They can also be loaded from a 32-bit status word, which software moves to and from a general register.

The evaluator is purely combinational. It takes a 4-bit condition field and the registered flags and raises a pass signal. A flag update becomes visible to the evaluator and to the packed word one cycle after it is presented.

Top module: `cond_flags`

## Requirements
- R1: After reset all four flags are zero, so the packed word reads 0 and code 0001 (not-equal) passes.
- R2: When alu_we_i is high on a clock edge, the flags take alu_flags_i, packed {N,Z,C,V} with N at bit 3. The new values are visible in the next cycle.
- R3: The packed status word carries N at bit 31, Z at bit 30, C at bit 29 and V at bit 28. Bits 27..0 always read zero.
- R4: When psr_we_i is high on a clock edge, all four flags load from bits 31..28 of psr_wdata_i. Bits 27..0 of the written word have no effect.
- R5: When psr_we_i and alu_we_i are both high in the same cycle, the status-word write wins.
- R6: With neither write enable high, the flags hold their values.
- R7: Codes 0000/0001 pass on Z set/clear. Codes 0010/0011 pass on C set/clear. Codes 0100/0101 pass on N set/clear. Codes 0110/0111 pass on V set/clear.
- R8: Code 1000 passes when C=1 and Z=0. Code 1001 passes when C=0 or Z=1.
- R9: Code 1010 passes when N equals V. Code 1011 passes when N differs from V.
- R10: Code 1100 passes when Z=0 and N equals V. Code 1101 passes when Z=1 or N differs from V.
- R11: Code 1110 always passes. Code 1111 never passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alu_we_i | input | 1 | Load flags from the ALU |
| alu_flags_i | input | 4 | ALU flags {N,Z,C,V} |
| psr_we_i | input | 1 | Load flags from the status word |
| psr_wdata_i | input | 32 | Status word to write |
| cond_i | input | 4 | Condition field |
| psr_rdata_o | output | 32 | Packed status word |
| pass_o | output | 1 | Condition is met |

## Verification
A wrong stored flag shows up in psr_rdata_o in the cycle after the faulty write, because the packed word exposes the flag register directly. Every flag value that is loaded is also swept through all sixteen condition codes. A corrupted flag or a mis-decoded predicate therefore changes pass_o within that same cycle. Priority and hold errors appear as a wrong packed word one cycle after the conflicting or idle edge.

// File: rtl/cond_pkg.sv
package cond_pkg;
  localparam int unsigned FLAG_W = 4;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned FLAG_LSB = WORD_W - FLAG_W;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [3:0] {
    CC_EQ = 4'h0, CC_NE = 4'h1, CC_HS = 4'h2, CC_LO = 4'h3,
    CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
    CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
  } cond_e;
endpackage

// File: rtl/flag_reg.sv
module flag_reg
  import cond_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                alu_we_i,
  input  flags_t              alu_flags_i,
  input  logic                psr_we_i,
  input  logic [WORD_W-1:0]   psr_wdata_i,
  output flags_t              flags_o
);
  flags_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flags_q <= '0;
    else if (psr_we_i) flags_q <= flags_t'(psr_wdata_i[WORD_W-1:FLAG_LSB]);
    else if (alu_we_i) flags_q <= alu_flags_i;
  end

  assign flags_o = flags_q;

  a_r5_psr_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psr_we_i |=> flags_q == $past(psr_wdata_i[WORD_W-1:FLAG_LSB]));
  a_r2_alu_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_we_i && !psr_we_i) |=> flags_q == $past(alu_flags_i));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alu_we_i && !psr_we_i) |=> $stable(flags_q));
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cond_pkg::*;
(
  input  flags_t      flags_i,
  input  logic [3:0]  cond_i,
  output logic        pass_o
);
  logic ge;
  assign ge = (flags_i.n == flags_i.v);

  always_comb begin
    unique case (cond_e'(cond_i))
      CC_EQ: pass_o = flags_i.z;
      CC_NE: pass_o = !flags_i.z;
      CC_HS: pass_o = flags_i.c;
      CC_LO: pass_o = !flags_i.c;
      CC_MI: pass_o = flags_i.n;
      CC_PL: pass_o = !flags_i.n;
      CC_VS: pass_o = flags_i.v;
      CC_VC: pass_o = !flags_i.v;
      CC_HI: pass_o = flags_i.c && !flags_i.z;
      CC_LS: pass_o = !flags_i.c || flags_i.z;
      CC_GE: pass_o = ge;
      CC_LT: pass_o = !ge;
      CC_GT: pass_o = !flags_i.z && ge;
      CC_LE: pass_o = flags_i.z || !ge;
      CC_AL: pass_o = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end

  always_comb begin
    a_r11_always: assert (cond_i != 4'hE || pass_o);
    a_r11_never:  assert (cond_i != 4'hF || !pass_o);
  end
endmodule

// File: rtl/cond_flags.sv
module cond_flags
  import cond_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         alu_we_i,
  input  logic [3:0]   alu_flags_i,
  input  logic         psr_we_i,
  input  logic [31:0]  psr_wdata_i,
  input  logic [3:0]   cond_i,
  output logic [31:0]  psr_rdata_o,
  output logic         pass_o
);
  flags_t flags;

  flag_reg i_flag_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alu_we_i    (alu_we_i),
    .alu_flags_i (flags_t'(alu_flags_i)),
    .psr_we_i    (psr_we_i),
    .psr_wdata_i (psr_wdata_i),
    .flags_o     (flags)
  );

  cond_eval i_cond_eval (
    .flags_i (flags),
    .cond_i  (cond_i),
    .pass_o  (pass_o)
  );

  assign psr_rdata_o = {flags, {FLAG_LSB{1'b0}}};

  a_r3_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psr_rdata_o[FLAG_LSB-1:0] == '0);
  a_r4_roundtrip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psr_we_i |=> psr_rdata_o[31:FLAG_LSB] == $past(psr_wdata_i[31:FLAG_LSB]));
endmodule

// File: tb/test_cond_flags.sv
module test_cond_flags;
  logic clk = 0, rst_n = 0;
  logic alu_we = 0, psr_we = 0;
  logic [3:0] alu_flags = 0, cond = 0;
  logic [31:0] psr_wdata = 0, psr_rdata;
  logic pass;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  cond_flags i_cond_flags (
    .clk_i(clk), .rst_ni(rst_n), .alu_we_i(alu_we), .alu_flags_i(alu_flags),
    .psr_we_i(psr_we), .psr_wdata_i(psr_wdata), .cond_i(cond),
    .psr_rdata_o(psr_rdata), .pass_o(pass));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic model(logic [3:0] f, logic [3:0] c);
    logic n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      0: return z;   1: return !z;  2: return cy;  3: return !cy;
      4: return n;   5: return !n;  6: return v;   7: return !v;
      8: return cy && !z;   9: return !cy || z;
      10: return n == v;    11: return n != v;
      12: return !z && n == v; 13: return z || n != v;
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(logic [3:0] c);
    if (c < 8) return "R7";
    if (c < 10) return "R8";
    if (c < 12) return "R9";
    if (c < 14) return "R10";
    return "R11";
  endfunction

  // sweep all codes against the expected flags; called at negedge
  task automatic sweep(logic [3:0] f);
    for (int c = 0; c < 16; c++) begin
      cond = c[3:0];
      #1;
      chk(req_of(c[3:0]), {31'b0, pass}, {31'b0, model(f, c[3:0])});
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", psr_rdata, 32'h0);
    cond = 4'h1; #1;
    chk("R1", {31'b0, pass}, 32'h1);
  endtask

  task automatic t_alu;
    for (int f = 0; f < 16; f++) begin
      alu_we = 1; alu_flags = f[3:0];
      @(negedge clk);
      alu_we = 0;
      chk("R2", psr_rdata, {f[3:0], 28'h0});
      sweep(f[3:0]);
    end
  endtask

  task automatic t_psr;
    psr_we = 1; psr_wdata = 32'hAFFF_FFFF;
    @(negedge clk);
    psr_we = 0;
    chk("R4", psr_rdata, 32'hA000_0000);
    chk("R3", {4'h0, psr_rdata[27:0]}, 32'h0);
    sweep(4'hA);
    psr_we = 1; psr_wdata = 32'h5000_0001;
    @(negedge clk);
    psr_we = 0;
    chk("R4", psr_rdata, 32'h5000_0000);
    sweep(4'h5);
  endtask

  task automatic t_priority;
    psr_we = 1; psr_wdata = 32'h3000_0000; alu_we = 1; alu_flags = 4'hC;
    @(negedge clk);
    psr_we = 0; alu_we = 0;
    chk("R5", psr_rdata, 32'h3000_0000);
  endtask

  task automatic t_hold;
    alu_flags = 4'hF; psr_wdata = 32'hF000_0000;
    repeat (3) @(negedge clk);
    chk("R6", psr_rdata, 32'h3000_0000);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_alu();
    t_psr();
    t_priority();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule